// File: doc/BRIEF.md
# Sector Parity Code Checker and Single-Bit Repair

This block checks one 512-byte sector after a read. It takes the 24-bit parity code held in the spare area for that sector and the code rebuilt from the data just read, and compares them. A mismatch gives a 24-bit syndrome. The block sorts the result into clean, corrected or uncorrectable, and for a single flipped data bit it names the byte and the bit.

When the repair option is built in, the block fixes that bit in an attached sector buffer before it signals completion. It does this with a one-cycle read of the byte followed by a write of the byte with the bit inverted. The verdict and the location stay on the outputs until the next accepted start.

Top module: `ecc_cmp_fix`

## Requirements
- R1: When the stored and computed codes are equal, status is 0 (clean), and the byte offset and bit index both read 0.
- R2: Each code carries twelve parity pairs. Bit k (k = 0..11) is the even parity of level 2^k, and bit 12+k is the odd parity of the same level. The syndrome is the bitwise XOR of the two codes.
- R3: A syndrome with exactly 12 bits set gives status 1 (corrected). The byte offset is syndrome bits 23:15, most significant first, and the bit index is syndrome bits 14:12.
- R4: A syndrome with exactly 1 or exactly 11 bits set gives status 2 (uncorrectable).
- R5: Every other nonzero syndrome weight gives status 2, except the case in R6. Whenever the status is not 1, the byte offset and bit index read 0.
- R6: A stored code of 24'hFFFFFF together with a computed code of 0 means an erased sector, and gives status 0.
- R7: A start accepted with no repair to do raises done for one cycle, on the first clock edge after the edge that accepted the start.
- R8: With repair built in, a corrected verdict reads the addressed byte (buf_rd_en, one cycle, read data valid in the next cycle). It then writes that byte back with the indicated bit inverted (buf_wr_en, one cycle). done rises on the edge after the write, three edges after the start. No other byte is written.
- R9: A start is accepted only while the block is idle; a start during a repair is ignored. Status, offset and bit index change only on the edge that accepts a start, and are held otherwise.
- R10: During reset, done, buf_rd_en and buf_wr_en are low, and the status, offset and bit index are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a check using the codes sampled on this edge |
| stored_code | input | 24 | Code read from the spare area |
| calc_code | input | 24 | Code rebuilt from the sector data |
| status | output | 2 | 0 clean, 1 corrected, 2 uncorrectable |
| err_byte | output | 9 | Byte offset of the flipped bit |
| err_bit | output | 3 | Bit index inside that byte |
| done | output | 1 | One-cycle completion pulse |
| buf_addr | output | 9 | Sector buffer byte address |
| buf_rd_en | output | 1 | Buffer read strobe |
| buf_rd_data | input | 8 | Buffer read data, one cycle after the strobe |
| buf_wr_en | output | 1 | Buffer write strobe |
| buf_wr_data | output | 8 | Repaired byte |

## Verification
Status, offset and bit index are due on the clock edge that accepts a start. done is due on the next edge for clean and uncorrectable results, and three edges later for a repair. The read strobe appears one edge after acceptance and the write strobe two edges after.

The bench reference model advances at each rising edge and predicts these outputs for every cycle. The outputs are sampled at the falling edge, which avoids any race with the edge that updates them. The buffer byte is compared in the cycle done appears, and the whole buffer is compared at the end.

// File: rtl/ecc_cmp_pkg.sv
package ecc_cmp_pkg;
  typedef enum logic [1:0] {
    ECC_CLEAN = 2'd0,
    ECC_FIXED = 2'd1,
    ECC_FATAL = 2'd2
  } ecc_stat_e;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_READ  = 2'd1,
    SQ_WRITE = 2'd2
  } seq_e;
endpackage

// File: rtl/ecc_syndrome.sv
module ecc_syndrome
  import ecc_cmp_pkg::*;
#(
  parameter int PAIRS = 12,
  parameter int BIT_W = 3
) (
  input  logic [2*PAIRS-1:0]     stored_code,
  input  logic [2*PAIRS-1:0]     calc_code,
  output ecc_stat_e              verdict,
  output logic [PAIRS-BIT_W-1:0] err_byte,
  output logic [BIT_W-1:0]       err_bit,
  output logic                   codes_match,
  output logic                   erased_hit
);
  localparam int CODE_W = 2 * PAIRS;
  localparam int CNT_W  = $clog2(CODE_W + 1);

  function automatic logic [PAIRS-1:0] even_row(input logic [CODE_W-1:0] c);
    return c[PAIRS-1:0];
  endfunction

  function automatic logic [PAIRS-1:0] odd_row(input logic [CODE_W-1:0] c);
    return c[CODE_W-1:PAIRS];
  endfunction

  function automatic logic [CNT_W-1:0] weight(input logic [CODE_W-1:0] v);
    logic [CNT_W-1:0] w;
    w = '0;
    for (int i = 0; i < CODE_W; i++) w = w + CNT_W'(v[i]);
    return w;
  endfunction

  logic [PAIRS-1:0] syn_even, syn_odd;
  logic [CNT_W-1:0] syn_weight;
  logic             one_hot_err, thin_err;

  assign syn_even    = even_row(stored_code) ^ even_row(calc_code);
  assign syn_odd     = odd_row(stored_code) ^ odd_row(calc_code);
  assign syn_weight  = weight({syn_odd, syn_even});
  assign codes_match = (stored_code == calc_code);
  assign erased_hit  = (&stored_code) && (calc_code == '0);
  assign one_hot_err = (syn_weight == CNT_W'(PAIRS));
  assign thin_err    = (syn_weight == CNT_W'(1)) || (syn_weight == CNT_W'(PAIRS - 1));

  always_comb begin
    verdict  = ECC_FATAL;
    err_byte = '0;
    err_bit  = '0;
    if (codes_match) begin
      verdict = ECC_CLEAN;
    end else if (one_hot_err) begin
      verdict  = ECC_FIXED;
      err_byte = syn_odd[PAIRS-1:BIT_W];
      err_bit  = syn_odd[BIT_W-1:0];
    end else if (thin_err) begin
      verdict = ECC_FATAL;
    end else if (erased_hit) begin
      verdict = ECC_CLEAN;
    end
  end
endmodule

// File: rtl/ecc_fix_seq.sv
module ecc_fix_seq
  import ecc_cmp_pkg::*;
#(
  parameter int OFS_W  = 9,
  parameter int BIT_W  = 3,
  parameter int DATA_W = 8,
  parameter bit FIX_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  ecc_stat_e         verdict_in,
  input  logic [OFS_W-1:0]  ofs_in,
  input  logic [BIT_W-1:0]  bit_in,
  input  logic [DATA_W-1:0] buf_rd_data,
  output ecc_stat_e         status_q,
  output logic [OFS_W-1:0]  ofs_q,
  output logic [BIT_W-1:0]  bit_q,
  output logic              done,
  output logic [OFS_W-1:0]  buf_addr,
  output logic              buf_rd_en,
  output logic              buf_wr_en,
  output logic [DATA_W-1:0] buf_wr_data,
  output logic              accept
);
  function automatic logic [DATA_W-1:0] flip_mask(input logic [BIT_W-1:0] b);
    return DATA_W'(1) << b;
  endfunction

  seq_e state;
  logic wants_rmw;

  generate
    if (FIX_EN) begin : g_fix
      assign wants_rmw = (verdict_in == ECC_FIXED);
    end else begin : g_nofix
      assign wants_rmw = 1'b0;
    end
  endgenerate

  assign accept = start && (state == SQ_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= SQ_IDLE;
      status_q <= ECC_CLEAN;
      ofs_q    <= '0;
      bit_q    <= '0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        SQ_IDLE: if (accept) begin
          status_q <= verdict_in;
          ofs_q    <= ofs_in;
          bit_q    <= bit_in;
          if (wants_rmw) state <= SQ_READ;
          else           done  <= 1'b1;
        end
        SQ_READ:  state <= SQ_WRITE;
        SQ_WRITE: begin
          state <= SQ_IDLE;
          done  <= 1'b1;
        end
        default:  state <= SQ_IDLE;
      endcase
    end
  end

  assign buf_addr    = ofs_q;
  assign buf_rd_en   = (state == SQ_READ);
  assign buf_wr_en   = (state == SQ_WRITE);
  assign buf_wr_data = buf_rd_data ^ flip_mask(bit_q);

  assert_fast_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !wants_rmw) |=> done);
  assert_no_done_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_rd_en || buf_wr_en) |-> !done);
  assert_read_then_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    buf_rd_en |=> (buf_wr_en && !buf_rd_en));
  assert_write_then_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    buf_wr_en |=> (done && !buf_wr_en));
  assert_status_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> ($stable(status_q) && $stable(ofs_q) && $stable(bit_q)));
endmodule

// File: rtl/ecc_cmp_fix.sv
module ecc_cmp_fix
  import ecc_cmp_pkg::*;
#(
  parameter int PAIRS  = 12,
  parameter int BIT_W  = 3,
  parameter int DATA_W = 8,
  parameter bit FIX_EN = 1'b1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic [2*PAIRS-1:0]     stored_code,
  input  logic [2*PAIRS-1:0]     calc_code,
  output logic [1:0]             status,
  output logic [PAIRS-BIT_W-1:0] err_byte,
  output logic [BIT_W-1:0]       err_bit,
  output logic                   done,
  output logic [PAIRS-BIT_W-1:0] buf_addr,
  output logic                   buf_rd_en,
  input  logic [DATA_W-1:0]      buf_rd_data,
  output logic                   buf_wr_en,
  output logic [DATA_W-1:0]      buf_wr_data
);
  localparam int OFS_W = PAIRS - BIT_W;

  ecc_stat_e        verdict, status_q;
  logic [OFS_W-1:0] loc_byte;
  logic [BIT_W-1:0] loc_bit;
  logic             codes_match, erased_hit, accept;

  ecc_syndrome #(.PAIRS(PAIRS), .BIT_W(BIT_W)) syn_i (
    .stored_code (stored_code),
    .calc_code   (calc_code),
    .verdict     (verdict),
    .err_byte    (loc_byte),
    .err_bit     (loc_bit),
    .codes_match (codes_match),
    .erased_hit  (erased_hit)
  );

  ecc_fix_seq #(.OFS_W(OFS_W), .BIT_W(BIT_W), .DATA_W(DATA_W), .FIX_EN(FIX_EN)) seq_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .verdict_in  (verdict),
    .ofs_in      (loc_byte),
    .bit_in      (loc_bit),
    .buf_rd_data (buf_rd_data),
    .status_q    (status_q),
    .ofs_q       (err_byte),
    .bit_q       (err_bit),
    .done        (done),
    .buf_addr    (buf_addr),
    .buf_rd_en   (buf_rd_en),
    .buf_wr_en   (buf_wr_en),
    .buf_wr_data (buf_wr_data),
    .accept      (accept)
  );

  assign status = status_q;

  assert_equal_clean_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && codes_match) |=> (status == 2'd0 && err_byte == '0 && err_bit == '0));
  assert_erased_clean_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && erased_hit) |=> (status == 2'd0));
  assert_fatal_no_loc_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (status == 2'd2) |-> (err_byte == '0 && err_bit == '0));
endmodule

// File: tb/ecc_cmp_fix_tb.sv
module ecc_cmp_fix_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [23:0] stored_code = '0, calc_code = '0;
  logic [1:0]  status;
  logic [8:0]  err_byte, buf_addr;
  logic [2:0]  err_bit;
  logic        done, buf_rd_en, buf_wr_en;
  logic [7:0]  buf_rd_data, buf_wr_data;

  int checks = 0, fails = 0, cycles = 0;

  logic [7:0] mem [512];
  logic [7:0] ref_mem [512];

  ecc_cmp_fix dut_i (
    .clk(clk), .rst_n(rst_n), .start(start),
    .stored_code(stored_code), .calc_code(calc_code),
    .status(status), .err_byte(err_byte), .err_bit(err_bit), .done(done),
    .buf_addr(buf_addr), .buf_rd_en(buf_rd_en), .buf_rd_data(buf_rd_data),
    .buf_wr_en(buf_wr_en), .buf_wr_data(buf_wr_data)
  );

  always #5 clk = ~clk;

  initial begin
    for (int i = 0; i < 512; i++) begin
      mem[i]     = 8'(i * 7 + 3);
      ref_mem[i] = 8'(i * 7 + 3);
    end
  end

  always @(posedge clk) begin
    if (buf_rd_en) buf_rd_data <= mem[buf_addr];
    if (buf_wr_en) mem[buf_addr] <= buf_wr_data;
  end

  task automatic check(input string rq, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  // behavioural reference: per-level walk of the pairs
  task automatic ref_eval(input logic [23:0] s, input logic [23:0] c,
                          output int st, output int off, output int bt, output string rq);
    int cnt = 0;
    off = 0; bt = 0;
    for (int k = 0; k < 12; k++) begin
      int e = int'(s[k] ^ c[k]);
      int o = int'(s[12+k] ^ c[12+k]);
      cnt += e + o;
      if (o != 0) begin
        if (k < 3) bt += (1 << k);
        else       off += (1 << (k - 3));
      end
    end
    if (s == c)                          begin st = 0; rq = "R1"; end
    else if (cnt == 12)                  begin st = 1; rq = "R3"; end
    else if (cnt == 1 || cnt == 11)      begin st = 2; rq = "R4"; end
    else if (s == 24'hFFFFFF && c == 0)  begin st = 0; rq = "R6"; end
    else                                 begin st = 2; rq = "R5"; end
    if (st != 1) begin off = 0; bt = 0; end
  endtask

  // reference model state, advanced on each rising edge
  int    m_busy = 0, m_st = 0, m_off = 0, m_bt = 0;
  bit    m_done = 0;
  string m_req = "R10", m_dreq = "R7";

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      m_busy = 0; m_st = 0; m_off = 0; m_bt = 0; m_done = 0; m_req = "R10";
    end else if (m_busy == 0 && start) begin
      ref_eval(stored_code, calc_code, m_st, m_off, m_bt, m_req);
      if (m_st == 1) begin
        m_busy = 2; m_done = 0; m_dreq = "R8";
        ref_mem[m_off] = ref_mem[m_off] ^ 8'(1 << m_bt);
      end else begin
        m_done = 1; m_dreq = "R7";
      end
    end else if (m_busy > 0) begin
      m_busy--;                 // R9: a start here is ignored
      m_done = (m_busy == 0);
    end else begin
      m_done = 0;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      check(m_dreq, "done", int'(done), int'(m_done));
      check(m_req, "status", int'(status), m_st);
      check(m_req, "err_byte", int'(err_byte), m_off);   // R2 location decode
      check(m_req, "err_bit", int'(err_bit), m_bt);
      check("R8", "buf_rd_en", int'(buf_rd_en), int'(m_busy == 2));
      check("R8", "buf_wr_en", int'(buf_wr_en), int'(m_busy == 1));
      if (m_done && m_st == 1)
        check("R8", "repaired byte", int'(mem[m_off]), int'(ref_mem[m_off]));
    end
  end

  function automatic logic [23:0] single_err(input int loc, input int bt);
    logic [23:0] m = '0;
    for (int k = 0; k < 12; k++) begin
      int v = (k < 3) ? ((bt >> k) & 1) : ((loc >> (k - 3)) & 1);
      if (v != 0) m[12+k] = 1'b1;
      else        m[k]    = 1'b1;
    end
    return m;
  endfunction

  task automatic run_op(input logic [23:0] s, input logic [23:0] c, input int hold);
    @(negedge clk); #1;
    start = 1'b1; stored_code = s; calc_code = c;
    for (int i = 1; i < hold; i++) begin
      @(negedge clk); #1;
      calc_code = c ^ 24'h000003;  // R9: changed codes while busy
    end
    @(negedge clk); #1;
    start = 1'b0;
    repeat (5) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10", "done", int'(done), 0);
    check("R10", "status", int'(status), 0);
    check("R10", "err_byte", int'(err_byte), 0);
    check("R10", "err_bit", int'(err_bit), 0);
    check("R10", "rd/wr", int'(buf_rd_en | buf_wr_en), 0);
    #1 rst_n = 1'b1;
    run_op(24'h5A3C96, 24'h5A3C96, 1);                            // R1
    run_op(24'h123456 ^ single_err(9'h1A5, 6), 24'h123456, 1);    // R2 R3
    run_op(24'hABCDEF ^ single_err(0, 0), 24'hABCDEF, 1);         // R3 offset 0
    run_op(24'h00F00F ^ single_err(511, 7), 24'h00F00F, 1);       // R3 last byte
    run_op(24'h777777 ^ 24'h000800, 24'h777777, 1);               // R4 weight 1
    run_op(24'h777777 ^ 24'h0007FF, 24'h777777, 1);               // R4 weight 11
    run_op(24'h777777 ^ 24'h000003, 24'h777777, 1);               // R5 weight 2
    run_op(24'hFFFFFF, 24'h000000, 1);                            // R6 erased
    run_op(24'hFFFFFF, 24'h000001, 1);                            // R5 not erased
    run_op(24'h314159 ^ single_err(9'h0C3, 2), 24'h314159, 3);    // R9 start held
    run_op(24'h111111 ^ 24'h000300, 24'h111111, 2);               // R7 back to back
    for (int i = 0; i < 512; i++)                                 // R8 nothing else touched
      if (mem[i] != ref_mem[i]) check("R8", "buffer byte", int'(mem[i]), int'(ref_mem[i]));
    check("R8", "buffer scan", 0, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    wait (cycles > 100000);
    checks++; fails++;
    $display("FAIL watchdog: actual %0d expected < 100000 cycles", cycles);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule